// File: doc/BRIEF.md
# Packed Subtractor With Saturation

This block is a 64-bit packed subtract stage that takes one cycle. It treats two 64-bit operands as parallel lanes and computes the first operand minus the second in each lane on its own. The lanes can be eight bytes, four 16-bit words or two 32-bit dwords. An 8-bit opcode selects the lane width and how a lane that overflows is handled. A lane can wrap modulo its width, clamp to the signed range, or clamp to the unsigned range. The two clamping policies exist only for byte and word lanes.

The caller presents both operands with the opcode and a valid strobe. One clock later the block returns the packed difference with a valid flag, and the caller writes that value back in place of the first operand. A new operation can start on every cycle. An opcode the block does not recognise produces no result, and the result port keeps the value it held before.

Top module: `packed_sub_sat`

## Requirements
- R1: Opcode 0xF8 does wrap-around subtraction on eight byte lanes. Byte k sits at bits 8k+7..8k, and each lane result is (a - b) mod 256.
- R2: Opcode 0xF9 does wrap-around subtraction on four 16-bit lanes. Lane k sits at bits 16k+15..16k, and each lane result is (a - b) mod 65536.
- R3: Opcode 0xFA does wrap-around subtraction on two 32-bit lanes. Lane k sits at bits 32k+31..32k.
- R4: Opcode 0xE8 does signed saturating byte subtraction. A true difference above 127 gives 0x7F, one below -128 gives 0x80, and any other difference is exact.
- R5: Opcode 0xE9 does signed saturating word subtraction. A true difference above 32767 gives 0x7FFF, one below -32768 gives 0x8000, and any other difference is exact.
- R6: Opcode 0xD8 does unsigned saturating byte subtraction. A lane whose second operand is larger than its first gives 0x00, and any other lane gives the exact difference.
- R7: Opcode 0xD9 does unsigned saturating word subtraction. A negative difference gives 0x0000.
- R8: When inValid is high with a recognised opcode, the result and outValid=1 appear on the next rising clock edge. Operations issued on consecutive cycles each produce their own result.
- R9: Any other opcode, including 0xEA and 0xDA, is ignored. With such an opcode, outValid is 0 on the next cycle and the result keeps its previous value. The result also holds while inValid is low.
- R10: While rstN is low, the result is zero and outValid is 0.
- R11: No borrow passes from one lane to the next. A lane's result depends only on that lane's bits of the two operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation request strobe |
| opcode | input | 8 | Operation select byte |
| srcA | input | 64 | Minuend, first operand |
| srcB | input | 64 | Subtrahend, second operand |
| outValid | output | 1 | Result is fresh this cycle |
| result | output | 64 | Packed difference |

## Verification
The assertions assume that inValid is low for the whole reset and that the operands and the opcode are steady at the clock edge on which a request is taken. The lane checks compare the result against the operands of the previous cycle, so they also need the operands to change only between edges. The bench drives every input on the falling edge and holds inValid low during reset. Its random stimulus draws opcodes from the seven valid codes plus a few invalid ones, so R9 is exercised as well.

// File: rtl/psub_pkg.sv
package psub_pkg;
  typedef enum logic [1:0] {LW_BYTE, LW_WORD, LW_DWORD} laneWidth_t;
  typedef enum logic [1:0] {OV_WRAP, OV_SSAT, OV_USAT} ovMode_t;

  typedef struct packed {
    logic       load;
    laneWidth_t width;
    ovMode_t    mode;
  } subCtrl_t;

  localparam logic [7:0] OPC_WRAP_B = 8'hF8;
  localparam logic [7:0] OPC_WRAP_W = 8'hF9;
  localparam logic [7:0] OPC_WRAP_D = 8'hFA;
  localparam logic [7:0] OPC_SSAT_B = 8'hE8;
  localparam logic [7:0] OPC_SSAT_W = 8'hE9;
  localparam logic [7:0] OPC_USAT_B = 8'hD8;
  localparam logic [7:0] OPC_USAT_W = 8'hD9;
endpackage

// File: rtl/psub_lane.sv
module psub_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  psub_pkg::ovMode_t mode,
  output logic [W-1:0]      y
);
  import psub_pkg::*;

  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] uDiff;
  logic [W:0] sDiff;
  logic       sOvf;

  always_comb begin
    uDiff = {1'b0, a} - {1'b0, b};
    sDiff = {a[W-1], a} - {b[W-1], b};
    sOvf  = sDiff[W] ^ sDiff[W-1];
    case (mode)
      OV_SSAT: y = sOvf ? (sDiff[W] ? SMIN : SMAX) : sDiff[W-1:0];
      OV_USAT: y = uDiff[W] ? '0 : uDiff[W-1:0];
      default: y = uDiff[W-1:0];
    endcase
  end
endmodule

// File: rtl/psub_ctrl.sv
module psub_ctrl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [7:0]           opcode,
  output psub_pkg::subCtrl_t   strobes,
  output logic                 outValid
);
  import psub_pkg::*;

  logic known;

  always_comb begin
    known         = 1'b1;
    strobes.width = LW_BYTE;
    strobes.mode  = OV_WRAP;
    case (opcode)
      OPC_WRAP_B: begin strobes.width = LW_BYTE;  strobes.mode = OV_WRAP; end
      OPC_WRAP_W: begin strobes.width = LW_WORD;  strobes.mode = OV_WRAP; end
      OPC_WRAP_D: begin strobes.width = LW_DWORD; strobes.mode = OV_WRAP; end
      OPC_SSAT_B: begin strobes.width = LW_BYTE;  strobes.mode = OV_SSAT; end
      OPC_SSAT_W: begin strobes.width = LW_WORD;  strobes.mode = OV_SSAT; end
      OPC_USAT_B: begin strobes.width = LW_BYTE;  strobes.mode = OV_USAT; end
      OPC_USAT_W: begin strobes.width = LW_WORD;  strobes.mode = OV_USAT; end
      default:    known = 1'b0;
    endcase
    strobes.load = inValid & known;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= strobes.load;
  end

  // R8: a fresh result always traces back to a request one cycle earlier
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R9: opcodes outside the valid set never yield a fresh result
  p_unknown_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode[7:4] != 4'hF && opcode[7:4] != 4'hE && opcode[7:4] != 4'hD)
      |=> !outValid);

  // R3: saturating policies are never selected for dword lanes
  p_dword_wrap_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.width == LW_DWORD) |-> strobes.mode == OV_WRAP);
endmodule

// File: rtl/psub_datapath.sv
module psub_datapath #(
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  psub_pkg::subCtrl_t strobes,
  input  logic [DATA_W-1:0]  srcA,
  input  logic [DATA_W-1:0]  srcB,
  output logic [DATA_W-1:0]  result
);
  import psub_pkg::*;

  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int DWORD_W  = 4 * BYTE_W;
  localparam int NBYTES   = DATA_W / BYTE_W;
  localparam int NWORDS   = DATA_W / WORD_W;
  localparam int NDWORDS  = DATA_W / DWORD_W;

  logic [DATA_W-1:0] byteRes;
  logic [DATA_W-1:0] wordRes;
  logic [DATA_W-1:0] dwordRes;
  logic [DATA_W-1:0] nextRes;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    psub_lane #(.W(BYTE_W)) lane_i (
      .a(srcA[i*BYTE_W +: BYTE_W]), .b(srcB[i*BYTE_W +: BYTE_W]),
      .mode(strobes.mode), .y(byteRes[i*BYTE_W +: BYTE_W]));
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    psub_lane #(.W(WORD_W)) lane_i (
      .a(srcA[i*WORD_W +: WORD_W]), .b(srcB[i*WORD_W +: WORD_W]),
      .mode(strobes.mode), .y(wordRes[i*WORD_W +: WORD_W]));
  end

  for (genvar i = 0; i < NDWORDS; i++) begin : g_dword
    psub_lane #(.W(DWORD_W)) lane_i (
      .a(srcA[i*DWORD_W +: DWORD_W]), .b(srcB[i*DWORD_W +: DWORD_W]),
      .mode(OV_WRAP), .y(dwordRes[i*DWORD_W +: DWORD_W]));
  end

  always_comb begin
    case (strobes.width)
      LW_WORD:  nextRes = wordRes;
      LW_DWORD: nextRes = dwordRes;
      default:  nextRes = byteRes;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             result <= '0;
    else if (strobes.load) result <= nextRes;
  end

  // R9: without a load the result register keeps its value
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.load) |-> $stable(result));

  for (genvar i = 0; i < NBYTES; i++) begin : g_chk
    // R1 and R11: each byte lane adds back to its own minuend
    p_wrap_byte_r1: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobes.load && strobes.width == LW_BYTE && strobes.mode == OV_WRAP)
        |-> BYTE_W'(result[i*BYTE_W +: BYTE_W] + $past(srcB[i*BYTE_W +: BYTE_W]))
            == $past(srcA[i*BYTE_W +: BYTE_W]));
    // R6: an unsigned clamped difference never exceeds the minuend
    p_usat_floor_r6: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobes.load && strobes.width == LW_BYTE && strobes.mode == OV_USAT)
        |-> result[i*BYTE_W +: BYTE_W] <= $past(srcA[i*BYTE_W +: BYTE_W]));
    // R4: non-negative minus negative can never come out negative
    p_ssat_sign_r4: assert property (@(posedge clk) disable iff (!rstN)
      $past(strobes.load && strobes.width == LW_BYTE && strobes.mode == OV_SSAT
            && !srcA[i*BYTE_W + BYTE_W-1] && srcB[i*BYTE_W + BYTE_W-1])
        |-> !result[i*BYTE_W + BYTE_W-1]);
  end
endmodule

// File: rtl/packed_sub_sat.sv
module packed_sub_sat #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);
  import psub_pkg::*;

  subCtrl_t strobes;

  psub_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .strobes(strobes), .outValid(outValid));

  psub_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .srcA(srcA), .srcB(srcB), .result(result));

  // R10: reset leaves the output idle and zero
  p_reset_zero_r10: assert property (@(posedge clk)
    !rstN |=> (!outValid && result == '0));
endmodule

// File: tb/packed_sub_sat_tb.sv
module packed_sub_sat_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        outValid;
  logic [63:0] result;

  int nChecks = 0;
  int nFails  = 0;
  logic [63:0] lastRes = '0;

  always #10 clk = ~clk;

  packed_sub_sat dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .srcA(srcA), .srcB(srcB), .outValid(outValid), .result(result));

  function automatic bit isKnown(input logic [7:0] op);
    return op inside {8'hF8, 8'hF9, 8'hFA, 8'hE8, 8'hE9, 8'hD8, 8'hD9};
  endfunction

  function automatic string tagOf(input logic [7:0] op);
    case (op)
      8'hF8: return "R1";
      8'hF9: return "R2";
      8'hFA: return "R3";
      8'hE8: return "R4";
      8'hE9: return "R5";
      8'hD8: return "R6";
      8'hD9: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [63:0] refSub(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b);
    int w; int m;
    logic [63:0] res;
    longint half, full, ua, ub, d;
    logic [63:0] mask;
    w = 8; m = 0; res = '0;
    case (op)
      8'hF9: begin w = 16; m = 0; end
      8'hFA: begin w = 32; m = 0; end
      8'hE8: begin w = 8;  m = 1; end
      8'hE9: begin w = 16; m = 1; end
      8'hD8: begin w = 8;  m = 2; end
      8'hD9: begin w = 16; m = 2; end
      default: begin w = 8; m = 0; end
    endcase
    mask = (64'd1 << w) - 64'd1;
    full = longint'(64'd1 << w);
    half = full / 2;
    for (int i = 0; i < 64 / w; i++) begin
      ua = longint'((a >> (i * w)) & mask);
      ub = longint'((b >> (i * w)) & mask);
      if (m == 1) begin
        if (ua >= half) ua = ua - full;
        if (ub >= half) ub = ub - full;
        d = ua - ub;
        if (d > half - 1) d = half - 1;
        if (d < -half) d = -half;
      end else begin
        d = ua - ub;
        if (m == 2 && d < 0) d = 0;
      end
      res = res | ((64'(d) & mask) << (i * w));
    end
    return res;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doOp(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b, input string extra);
    logic [63:0] exp;
    @(negedge clk);
    inValid = 1'b1; opcode = op; srcA = a; srcB = b;
    @(posedge clk);
    #2;
    inValid = 1'b0;
    if (isKnown(op)) begin
      exp = refSub(op, a, b);
      check({tagOf(op), extra, " R8 valid"}, {63'd0, outValid}, 64'd1);
      check({tagOf(op), extra}, result, exp);
      lastRes = exp;
    end else begin
      check({"R9 valid", extra}, {63'd0, outValid}, 64'd0);
      check({"R9 hold", extra}, result, lastRes);
    end
  endtask

  initial begin
    logic [7:0] ops [9] = '{8'hF8, 8'hF9, 8'hFA, 8'hE8, 8'hE9, 8'hD8, 8'hD9, 8'hEA, 8'hDA};
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    #2;
    check("R10 valid", {63'd0, outValid}, 64'd0);
    check("R10 result", result, 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // directed corners
    doOp(8'hE8, 64'h7F80_0000_7F80_0102, 64'hFF01_7F81_8001_0201, " ssat byte");
    doOp(8'hE9, 64'h8000_7FFF_0005_8000, 64'h0001_FFFF_0007_7FFF, " ssat word");
    doOp(8'hD8, 64'h0010_FF00_0180_2020, 64'h0111_00FF_0280_1030, " usat byte");
    doOp(8'hD9, 64'h0000_FFFF_1234_0001, 64'h0001_0000_1234_0002, " usat word");
    doOp(8'hF8, 64'h0000_0000_0000_0100, 64'h0000_0000_0000_0001, " R11 no borrow byte");
    doOp(8'hF9, 64'h0001_0000_0001_0000, 64'h0000_0001_0000_0001, " R11 no borrow word");
    doOp(8'hFA, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001, " R11 no borrow dword");
    doOp(8'hEA, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, " dword ssat refused");
    doOp(8'hDA, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, " dword usat refused");
    // R9: idle cycles keep the result
    repeat (2) @(posedge clk);
    #2;
    check("R9 idle hold", result, lastRes);
    check("R9 idle valid", {63'd0, outValid}, 64'd0);

    // constrained random, back to back (R8)
    for (int n = 0; n < 400; n++) begin
      int pick;
      logic [63:0] a, b;
      pick = ($urandom % 20 == 0) ? 7 + ($urandom % 2) : ($urandom % 7);
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom % 4 == 0) b = a ^ {32'd0, $urandom % 4};
      doOp(ops[pick], a, b, " random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog R8 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule